// File: doc/BRIEF.md
# Standby Sequencer with Oscillation-Settling Wake Timer

This block puts a chip into a low-power standby state and brings it back out. Software arms it by setting a standby-enable bit and then raises a sleep request. The block then drops its clock-enable output, which gates the system clock. A non-maskable interrupt or any external interrupt line wakes it. The clock does not come back at once: an 8-bit up-counter runs from a software-loaded start value through a selectable prescaler. The clock is enabled again only when that counter wraps from 0xFF to 0x00, which gives the oscillator time to settle.

On wake, the block latches a code that names the interrupt source. If software leaves the standby-enable bit set after waking, the counter keeps running from zero and the block returns to standby by itself when the counter reaches 0x80. If software clears the bit, the counter stops. An active-low reset cancels standby at any time, without waiting for a clock edge.

The sequencer has four states. In RUN the clock is enabled. STANDBY is entered from RUN, either on an armed sleep request or on the automatic re-entry count. SETTLE is entered from STANDBY on any wake source. WAKE is entered from SETTLE on counter overflow, lasts exactly one cycle, and always returns to RUN.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: In RUN, a sleep request while the standby-enable bit (address 0, bit 0) is 1 moves the block to STANDBY at the next clock edge, and clk_en is low from then on.
- R2: A sleep request while the standby-enable bit is 0 is ignored: clk_en stays high and the state stays RUN.
- R3: In STANDBY, clk_en stays low until a wake source appears. A wake source is nmi_req or any bit of irq_req, and no mask applies to it. The clock edge that sees a wake source moves the block to SETTLE.
- R4: Clock-select encodings 0 to 7 (address 1, bits 2:0) give prescale ratios of 1, 4, 16, 32, 64, 256, 1024 and 4096 respectively. Let the counter start value be C and the ratio be P. Counting from the edge that enters SETTLE, clk_en rises after (256 - C) * P + 1 clock edges.
- R5: WAKE lasts one cycle, with clk_en and wake_pulse both high. The block then returns to RUN with wake_pulse low.
- R6: When the block leaves STANDBY, the source code is latched to evt_code and to address 3. The code is 0x10 for nmi_req and 0x20 + i for irq_req[i]. nmi_req beats any IRQ, and a lower IRQ index beats a higher one.
- R7: If the standby-enable bit is still 1 after wake, the counter counts on from 0. STANDBY is re-entered when it reaches 0x80, which is 128 * P edges after the edge that entered WAKE.
- R8: If software clears the standby-enable bit after wake while the timer-enable bit is 0, the counter holds its value and the block stays in RUN.
- R9: A low rst_n forces RUN and a high clk_en at once, without waiting for a clock edge, and clears every register to 0.
- R10: Entering standby clears the timer start-control register (address 4). The enable, timer-control and other registers keep their values.
- R11: Register map:
  - address 1 holds the timer-enable bit in bit 7 and the clock-select field in bits 2:0, and its bits 6:3 read 0;
  - a write to address 2 loads the counter, and a read of address 2 returns it;
  - unmapped addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset; cancels standby |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| sleep_req | input | 1 | Sleep request from the processor |
| nmi_req | input | 1 | Non-maskable interrupt request (wake source) |
| irq_req | input | 4 | External interrupt requests (wake sources) |
| clk_en | output | 1 | System clock enable; low in STANDBY and SETTLE |
| wake_pulse | output | 1 | High for the single WAKE cycle |
| evt_code | output | 8 | Latched wake-source code |

## Verification
The non-maskable interrupt and one or more external interrupt lines can rise in the same standby cycle. The latched code must then follow a fixed priority. The random trials draw independent patterns for nmi_req and the four IRQ lines, so many trials raise several sources together. A directed case pairs the NMI with every IRQ line. Each latched code is compared with a bench priority function, and each settle length is checked against the ratio-times-distance formula.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STANDBY = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_WAKE    = 2'd3
    } stby_state_e;

    localparam int PRE_W  = 12;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_TCTL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT    = 3'd2;
    localparam logic [ADDR_W-1:0] A_EVT    = 3'd3;
    localparam logic [ADDR_W-1:0] A_TSTART = 3'd4;

    localparam logic [7:0] CODE_NMI      = 8'h10;
    localparam logic [7:0] CODE_IRQ_BASE = 8'h20;

    // terminal value of the prescaler for each clock-select encoding
    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] sel);
        logic [PRE_W-1:0] lim;
        unique case (sel)
            3'd0: lim = PRE_W'(0);
            3'd1: lim = PRE_W'(3);
            3'd2: lim = PRE_W'(15);
            3'd3: lim = PRE_W'(31);
            3'd4: lim = PRE_W'(63);
            3'd5: lim = PRE_W'(255);
            3'd6: lim = PRE_W'(1023);
            default: lim = PRE_W'(4095);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/stby_src_enc.sv
module stby_src_enc #(
    parameter int NIRQ   = 4,
    parameter int CODE_W = 8
) (
    input  logic              nmi,
    input  logic [NIRQ-1:0]   irq,
    output logic              any,
    output logic [CODE_W-1:0] code
);
    import stby_pkg::*;

    logic [NIRQ-1:0] line_hit;

    genvar g;
    generate
        for (g = 0; g < NIRQ; g++) begin : g_line
            // a line wins only if no lower-indexed line is active
            if (g == 0) begin : g_first
                assign line_hit[g] = irq[g];
            end else begin : g_rest
                assign line_hit[g] = irq[g] && (irq[g-1:0] == '0);
            end
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (line_hit[i]) code = CODE_W'(CODE_IRQ_BASE) + CODE_W'(i);
        end
        if (nmi) code = CODE_W'(CODE_NMI);
        any = nmi || (irq != '0);
    end

endmodule

// File: rtl/stby_wake_timer.sv
module stby_wake_timer #(
    parameter int CNT_W    = 8,
    parameter int REARM_AT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [2:0]       sel,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             rearm_hit
);
    import stby_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] REARM_PRE = CNT_W'(REARM_AT - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = run && (pre_q == div_limit(sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt       = cnt_q;
    assign ovf       = tick && (cnt_q == CNT_MAX);
    assign rearm_hit = tick && (cnt_q == REARM_PRE);

endmodule

// File: rtl/stby_regs.sv
module stby_regs #(
    parameter int DW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [stby_pkg::ADDR_W-1:0] addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    input  logic [DW-1:0]               cnt_val,
    input  logic [DW-1:0]               evt_in,
    input  logic                        evt_load,
    input  logic                        clr_tstart,
    output logic                        stby_en,
    output logic                        tmr_en,
    output logic [2:0]                  sel,
    output logic                        cnt_ld,
    output logic [DW-1:0]               cnt_ld_val,
    output logic [DW-1:0]               evt_q
);
    import stby_pkg::*;

    logic          stby_en_q;
    logic          tmr_en_q;
    logic [2:0]    sel_q;
    logic [DW-1:0] tstart_q;
    logic [DW-1:0] evt_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stby_en_q <= 1'b0;
            tmr_en_q  <= 1'b0;
            sel_q     <= '0;
            tstart_q  <= '0;
            evt_r     <= '0;
        end else begin
            if (we && addr == A_CTRL) stby_en_q <= wdata[0];
            if (we && addr == A_TCTL) begin
                tmr_en_q <= wdata[DW-1];
                sel_q    <= wdata[2:0];
            end
            if (clr_tstart) begin
                tstart_q <= '0;
            end else if (we && addr == A_TSTART) begin
                tstart_q <= wdata;
            end
            if (evt_load) evt_r <= evt_in;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:   rdata = DW'(stby_en_q);
            A_TCTL:   rdata = {tmr_en_q, {(DW-4){1'b0}}, sel_q};
            A_CNT:    rdata = cnt_val;
            A_EVT:    rdata = evt_r;
            A_TSTART: rdata = tstart_q;
            default:  rdata = '0;
        endcase
    end

    assign stby_en    = stby_en_q;
    assign tmr_en     = tmr_en_q;
    assign sel        = sel_q;
    assign cnt_ld     = we && (addr == A_CNT);
    assign cnt_ld_val = wdata;
    assign evt_q      = evt_r;

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_req,
    input  logic                  stby_en,
    input  logic                  tmr_en,
    input  logic                  wake_any,
    input  logic                  ovf,
    input  logic                  rearm_hit,
    output stby_pkg::stby_state_e state_o,
    output logic                  clk_en,
    output logic                  enter_stby,
    output logic                  evt_load,
    output logic                  count_on
);
    import stby_pkg::*;

    stby_state_e state_q, state_d;
    logic        rearm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stby_en && (sleep_req || (rearm_q && rearm_hit)))
                    state_d = ST_STANDBY;
            end
            ST_STANDBY: if (wake_any) state_d = ST_SETTLE;
            ST_SETTLE:  if (ovf)      state_d = ST_WAKE;
            ST_WAKE:    state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        clk_en     = (state_q == ST_RUN) || (state_q == ST_WAKE);
        enter_stby = (state_q == ST_RUN) && (state_d == ST_STANDBY);
        evt_load   = (state_q == ST_STANDBY) && wake_any;
        count_on   = (state_q == ST_SETTLE) || (state_q == ST_WAKE) ||
                     ((state_q == ST_RUN) && ((rearm_q && stby_en) || tmr_en));
    end

    // post-wake re-entry tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rearm_q <= 1'b0;
        end else if (state_q == ST_SETTLE && ovf) begin
            rearm_q <= 1'b1;
        end else if (!stby_en || enter_stby) begin
            rearm_q <= 1'b0;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/pwr_standby_ctrl.sv
module pwr_standby_ctrl #(
    parameter int NIRQ     = 4,
    parameter int DATA_W   = 8,
    parameter int REARM_AT = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [stby_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        sleep_req,
    input  logic                        nmi_req,
    input  logic [NIRQ-1:0]             irq_req,
    output logic                        clk_en,
    output logic                        wake_pulse,
    output logic [DATA_W-1:0]           evt_code
);
    import stby_pkg::*;

    stby_state_e       fsm_state;
    logic              stby_en_w, tmr_en_w, cnt_ld_w, evt_load_w, enter_w;
    logic              count_on_w, ovf_w, rearm_hit_w, wake_any_w;
    logic [2:0]        sel_w;
    logic [DATA_W-1:0] cnt_w, cnt_ld_val_w, src_code_w;

    stby_src_enc #(.NIRQ(NIRQ), .CODE_W(DATA_W)) u_enc (
        .nmi  (nmi_req),
        .irq  (irq_req),
        .any  (wake_any_w),
        .code (src_code_w)
    );

    stby_regs #(.DW(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .cnt_val    (cnt_w),
        .evt_in     (src_code_w),
        .evt_load   (evt_load_w),
        .clr_tstart (enter_w),
        .stby_en    (stby_en_w),
        .tmr_en     (tmr_en_w),
        .sel        (sel_w),
        .cnt_ld     (cnt_ld_w),
        .cnt_ld_val (cnt_ld_val_w),
        .evt_q      (evt_code)
    );

    stby_wake_timer #(.CNT_W(DATA_W), .REARM_AT(REARM_AT)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (count_on_w),
        .sel       (sel_w),
        .ld        (cnt_ld_w),
        .ld_val    (cnt_ld_val_w),
        .cnt       (cnt_w),
        .ovf       (ovf_w),
        .rearm_hit (rearm_hit_w)
    );

    stby_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .stby_en    (stby_en_w),
        .tmr_en     (tmr_en_w),
        .wake_any   (wake_any_w),
        .ovf        (ovf_w),
        .rearm_hit  (rearm_hit_w),
        .state_o    (fsm_state),
        .clk_en     (clk_en),
        .enter_stby (enter_w),
        .evt_load   (evt_load_w),
        .count_on   (count_on_w)
    );

    assign wake_pulse = (fsm_state == ST_WAKE);

endmodule

// File: rtl/stby_checker.sv
module stby_checker #(
    parameter int NIRQ = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input stby_pkg::stby_state_e state,
    input logic                  sleep_req,
    input logic                  stby_en,
    input logic                  nmi,
    input logic [NIRQ-1:0]       irq,
    input logic                  clk_en,
    input logic                  wake_pulse,
    input logic [7:0]            evt_code,
    input logic                  ovf
);
    import stby_pkg::*;

    a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && stby_en) |=> (state == ST_STANDBY && !clk_en));

    a_r2_r8_stay_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !stby_en) |=> (state == ST_RUN && clk_en));

    a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && (nmi || (irq != '0))) |=> (state == ST_SETTLE && !clk_en));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && !nmi && (irq == '0)) |=> (state == ST_STANDBY));

    a_r4_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !ovf) |=> (state == ST_SETTLE && !clk_en));

    a_r4_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && ovf) |=> (wake_pulse && clk_en));

    a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> (state == ST_RUN && !wake_pulse));

    a_r6_nmi_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && nmi) |=> (evt_code == CODE_NMI));

    a_r6_irq0_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && !nmi && irq[0]) |=> (evt_code == CODE_IRQ_BASE));

endmodule

bind pwr_standby_ctrl stby_checker #(.NIRQ(NIRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (fsm_state),
    .sleep_req  (sleep_req),
    .stby_en    (stby_en_w),
    .nmi        (nmi_req),
    .irq        (irq_req),
    .clk_en     (clk_en),
    .wake_pulse (wake_pulse),
    .evt_code   (evt_code),
    .ovf        (ovf_w)
);

// File: tb/tb_pwr_standby_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_standby_ctrl;
    import stby_pkg::*;

    localparam int NIRQ = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sleep_req = 1'b0;
    logic       nmi_req = 1'b0;
    logic [3:0] irq_req = '0;
    logic       clk_en, wake_pulse;
    logic [7:0] evt_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_standby_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .nmi_req(nmi_req), .irq_req(irq_req), .clk_en(clk_en),
        .wake_pulse(wake_pulse), .evt_code(evt_code)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, what, act, act, exp, exp);
        end
    endtask

    function automatic int ratio_of(input int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 16;
            3: return 32;
            4: return 64;
            5: return 256;
            6: return 1024;
            default: return 4096;
        endcase
    endfunction

    function automatic int code_of(input logic n, input logic [3:0] q);
        if (n) return 'h10;
        for (int i = 0; i < 4; i++) if (q[i]) return 'h20 + i;
        return 0;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic sleep_pulse();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    // arm, sleep, wake with the given sources, measure settle length
    task automatic standby_cycle(input int s, input int c0, input logic n,
                                 input logic [3:0] q, input logic [7:0] ts);
        int v, cyc;
        wr(A_CTRL, 8'h01);
        wr(A_TCTL, 8'(s));
        wr(A_CNT, 8'(c0));
        wr(A_TSTART, ts);
        sleep_pulse();
        check("R1", int'(clk_en), 0, "clk_en after armed sleep");
        rd(A_TSTART, v); check("R10", v, 0, "start-control cleared on entry");
        rd(A_CTRL, v);   check("R10", v, 1, "enable bit retained");
        rd(A_TCTL, v);   check("R10", v, s, "timer control retained");
        repeat (3) @(negedge clk);
        check("R3", int'(clk_en), 0, "clk_en while idle in standby");
        nmi_req = n; irq_req = q;
        @(posedge clk); cyc = 1;
        @(negedge clk); nmi_req = 1'b0; irq_req = '0;
        while (clk_en !== 1'b1 && cyc < 20000) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
        check("R4", cyc, (256 - c0) * ratio_of(s) + 1, "settle edges");
        check("R5", int'(wake_pulse), 1, "wake_pulse on clock return");
        check("R6", int'(evt_code), code_of(n, q), "evt_code port");
        rd(A_EVT, v); check("R6", v, code_of(n, q), "event register");
    endtask

    initial begin
        int v, w, m;
        void'($urandom(32'd7715));
        #12;
        // reset state
        check("R9", int'(clk_en), 1, "clk_en during reset");
        @(negedge clk); rst_n = 1'b1;
        check("R9", int'(wake_pulse), 0, "wake_pulse after reset");
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); check("R9", v, 0, "register after reset");
        end

        // register map
        wr(A_TCTL, 8'hFF); rd(A_TCTL, v); check("R11", v, 'h87, "timer control readback");
        wr(A_CNT, 8'h3C);  rd(A_CNT, v);  check("R11", v, 'h3C, "counter load");
        rd(3'd5, v); check("R11", v, 0, "unmapped 5");
        rd(3'd7, v); check("R11", v, 0, "unmapped 7");
        wr(A_TCTL, 8'h00);

        // sleep without the enable bit
        wr(A_CTRL, 8'h00);
        sleep_pulse();
        check("R2", int'(clk_en), 1, "clk_en after unarmed sleep");
        repeat (4) @(negedge clk);
        check("R2", int'(clk_en), 1, "clk_en stays high");

        // NMI with every IRQ line, then stop counter
        standby_cycle(0, 250, 1'b1, 4'hF, 8'hA5);
        @(negedge clk);
        check("R5", int'(wake_pulse), 0, "wake_pulse single cycle");
        check("R5", int'(clk_en), 1, "clk_en in run after wake");
        wr(A_CTRL, 8'h00);
        rd(A_CNT, v);
        repeat (40) @(negedge clk);
        rd(A_CNT, w);
        check("R8", w, v, "counter holds after enable cleared");
        check("R8", int'(clk_en), 1, "no re-entry after enable cleared");

        // automatic re-entry at ratio 1 and 4
        for (int s = 0; s < 2; s++) begin
            standby_cycle(s, 255, 1'b0, 4'b1010, 8'h3C);
            m = 0;
            while (clk_en === 1'b1 && m < 20000) begin
                @(posedge clk); m++;
                @(negedge clk);
            end
            check("R7", m, 128 * ratio_of(s), "edges to automatic re-entry");
            rd(A_CNT, v); check("R7", v, 'h80, "counter at re-entry");
            irq_req = 4'b0100;
            @(negedge clk); irq_req = '0;
            m = 1;
            while (clk_en !== 1'b1 && m < 20000) begin
                @(posedge clk); m++;
                @(negedge clk);
            end
            check("R4", m, 128 * ratio_of(s) + 1, "settle from 0x80");
            check("R6", int'(evt_code), 'h22, "irq2 code after re-entry");
            wr(A_CTRL, 8'h00);
        end

        // random trials
        for (int t = 0; t < 24; t++) begin
            int s, r, mx, nn;
            logic n;
            logic [3:0] q;
            s = int'($urandom % 8);
            r = ratio_of(s);
            mx = 2048 / r;
            if (mx > 256) mx = 256;
            nn = 1 + int'($urandom % mx);
            n = ($urandom % 3) == 0;
            q = 4'($urandom);
            if (!n && q == 0) q = 4'(1 << ($urandom % 4));
            standby_cycle(s, 256 - nn, n, q, 8'($urandom));
            wr(A_CTRL, 8'h00);
        end

        // asynchronous reset during settle
        standby_cycle(0, 255, 1'b1, 4'h0, 8'h11);
        wr(A_CTRL, 8'h01);
        wr(A_TCTL, 8'h07);
        wr(A_CNT, 8'h00);
        sleep_pulse();
        nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
        repeat (50) @(negedge clk);
        check("R3", int'(clk_en), 0, "clk_en low in settle");
        #1 rst_n = 1'b0;
        #0.5;
        check("R9", int'(clk_en), 1, "clk_en forced by reset");
        rd(A_CTRL, v); check("R9", v, 0, "enable cleared by reset");
        rd(A_EVT, v);  check("R9", v, 0, "event cleared by reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R9", int'(clk_en), 1, "run after reset release");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule